// File: doc/BRIEF.md
# DMA Channel Burst Sequencer

This block is one channel of a DMA engine. It pulls data beats from a source read port and pushes them to a destination write port. The beats pass through a small internal FIFO. Software programs the channel with a single 32-bit control word. A per-transfer block beat count says how many beats make up one block. Each peripheral request, picked from a bank of request lines, moves a fixed amount of data. That amount is set by the trigger granularity: one burst, one block, or a whole transaction after which the channel turns itself off.

Within a burst, destination writes are held back until a programmed number of beats has collected in the FIFO, or until the burst has read all of its beats. Turning the channel off while a burst is running is deferred: the current burst finishes and the FIFO drains first. A one-shot software reset returns the control word to zero, but only while the channel is off. A standby input can freeze the channel unless the control word allows it to keep running.

Top module: `dma_burst_channel`

## Requirements
- R1: Control word layout, read back on `ctrl_rdata` after a write. Fields: bits 29:28 fill threshold, 27:24 burst length code, 21:20 trigger granularity, 15:8 request line select, bit 6 run-in-standby, bit 1 enable, bit 0 software reset. All other bits read 0. Reset value is 0.
- R2: A burst length code N moves N+1 beats per burst. When fewer beats than that remain in the block, the last burst carries only the remainder.
- R3: Threshold codes 0, 1, 2 and 3 hold back the first write of a burst until 1, 2, 4 or 8 beats have been read, or until the burst's reads are complete if the burst is shorter. With burst length code 0 the threshold has no effect.
- R4: Granularity code 2: each request moves exactly one burst.
- R5: Granularity code 0: each request moves a whole block, and enable stays 1 afterwards. Code 1 behaves the same as code 0.
- R6: Granularity code 3: one request moves a whole block, after which enable reads 0.
- R7: The request line select picks one line of `trig_req`. Line 0 never starts a transfer, and lines that are not selected are ignored.
- R8: A request that arrives while a burst is in progress is held as a single pending request. Any further requests in that window are dropped.
- R9: Writing enable 0 during a burst keeps enable at 1 until the burst has finished and the FIFO is empty. Then enable clears and the rest of the block is abandoned without a done pulse. While enable is 0, no beat is offered on either port.
- R10: Writing 1 to bit 0 while enable is 0 makes bit 0 read 1 for one cycle, after which the whole word reads 0. While enable is 1 that bit is ignored and the other fields are written normally.
- R11: While `standby` is 1 and run-in-standby is 0, neither `rd_valid` nor `wr_valid` is asserted. When run-in-standby is 1, standby has no effect.
- R12: `done` is high for exactly one cycle, in the cycle after the last write of a block is accepted.
- R13: Beats are written in the order they were read, with none lost or duplicated, and the FIFO never holds more than its depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Control word read-back |
| blk_beats | input | CW | Beats per block |
| trig_req | input | NTRIG | Peripheral request lines |
| standby | input | 1 | System standby indication |
| rd_valid | output | 1 | Source read beat request |
| rd_ready | input | 1 | Source accepts the read this cycle |
| rd_data | input | DW | Source data for the accepted read |
| wr_valid | output | 1 | Destination write beat valid |
| wr_ready | input | 1 | Destination accepts the write |
| wr_data | output | DW | Destination write data |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | Block completion pulse |

## Verification
Most internal faults in this block show up at the ports within one burst of at most sixteen beats. A wrong burst or block counter produces the wrong number of read handshakes per request. A wrong FIFO occupancy moves the first `wr_valid` of a burst earlier or later than the threshold allows, or corrupts the write data sequence. A lost or duplicated pending request shows up as a missing or extra burst once the next quiet period arrives. A faulty enable or reset sequence is visible on `ctrl_rdata` in the cycle right after the write, or when the drained burst ends.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    // Trigger granularity codes (control word bits 21:20)
    typedef enum logic [1:0] {
        ACT_BLOCK = 2'd0,
        ACT_RSVD  = 2'd1,
        ACT_BURST = 2'd2,
        ACT_XACT  = 2'd3
    } trig_act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] thr;
        logic [3:0] blen;
        trig_act_e  act;
        logic [7:0] src;
        logic       stby_run;
    } chan_cfg_t;

    // Beats that must be buffered before destination writes begin
    function automatic logic [4:0] thr_beats(input logic [1:0] code);
        return 5'd1 << code;
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        xfer_active,
    input  logic        burst_end,
    input  logic        xact_end,
    output chan_cfg_t   cfg,
    output logic        en,
    output logic [31:0] rdata
);

    typedef struct packed {
        chan_cfg_t cfg;
        logic      en;
        logic      swrst;
        logic      dis_pend;
    } reg_t;

    reg_t q, d;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:30], wdata[23:22], wdata[19:16], wdata[7], wdata[5:2]};

    always_comb begin
        d = q;
        if (q.swrst) begin
            // reset cycle completes: everything back to zero
            d = '0;
        end else begin
            if (burst_end && q.en) begin
                if (q.dis_pend || xact_end) begin
                    d.en       = 1'b0;
                    d.dis_pend = 1'b0;
                end
            end
            if (wr_en) begin
                if (wdata[0] && !q.en) begin
                    d.swrst = 1'b1;
                end else begin
                    d.cfg.thr      = wdata[29:28];
                    d.cfg.blen     = wdata[27:24];
                    d.cfg.act      = trig_act_e'(wdata[21:20]);
                    d.cfg.src      = wdata[15:8];
                    d.cfg.stby_run = wdata[6];
                    if (wdata[1]) begin
                        d.en       = 1'b1;
                        d.dis_pend = 1'b0;
                    end else if (q.en) begin
                        if (xfer_active && !burst_end) begin
                            d.dis_pend = 1'b1;
                        end else begin
                            d.en       = 1'b0;
                            d.dis_pend = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg   = q.cfg;
    assign en    = q.en;
    assign rdata = {2'b00, q.cfg.thr, q.cfg.blen, 2'b00, q.cfg.act, 4'b0000,
                    q.cfg.src, 1'b0, q.cfg.stby_run, 4'b0000, q.en, q.swrst};

endmodule

// File: rtl/dma_trig_pick.sv
module dma_trig_pick #(
    parameter int NTRIG = 256
) (
    input  logic [NTRIG-1:0] req,
    input  logic [7:0]       src,
    input  logic             arm,
    output logic             hit
);

    logic sel;

    always_comb begin
        sel = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (src == 8'(i)) sel = req[i];
        end
    end

    // line 0 is permanently inactive
    assign hit = sel && (src != 8'd0) && arm;

endmodule

// File: rtl/dma_beat_fifo.sv
module dma_beat_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int CNW   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [DW-1:0]  push_data,
    input  logic           pop,
    output logic [DW-1:0]  head,
    output logic [CNW-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0]  wp;
        logic [AW-1:0]  rp;
        logic [CNW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push) d.wp = step(q.wp);
        if (pop)  d.rp = step(q.rp);
        d.cnt = q.cnt + CNW'(push) - CNW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wp] <= push_data;
    end

    assign head  = mem[q.rp];
    assign count = q.cnt;

endmodule

// File: rtl/dma_burst_channel.sv
module dma_burst_channel
    import dma_chan_pkg::*;
#(
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int NTRIG      = 256,
    parameter int CW         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    output logic [31:0]      ctrl_rdata,
    input  logic [CW-1:0]    blk_beats,
    input  logic [NTRIG-1:0] trig_req,
    input  logic             standby,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [DW-1:0]    wr_data,
    output logic             busy,
    output logic             done
);

    // FIFO_DEPTH must be at least 16 so a full burst fits
    localparam int FCW = $clog2(FIFO_DEPTH + 1);
    localparam int BW  = 5;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] blk_left;
        logic [BW-1:0] brst_left;
        logic          pend;
        logic          done;
    } seq_t;

    seq_t q, d;

    chan_cfg_t      cfg;
    logic           en;
    logic [FCW-1:0] fifo_cnt;
    logic           fifo_full;
    logic           halt;
    logic           in_xfer;
    logic           trig_hit;
    logic           rd_fire;
    logic           wr_fire;
    logic           burst_end;
    logic           last_wr;
    logic           xact_end;
    logic [BW-1:0]  blen_beats;
    logic [BW-1:0]  thr_eff;
    logic [CW-1:0]  load_len;

    function automatic logic [BW-1:0] clip(input logic [CW-1:0] left, input logic [BW-1:0] cap);
        if (left < CW'(cap)) return left[BW-1:0];
        return cap;
    endfunction

    dma_chan_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_we),
        .wdata      (ctrl_wdata),
        .xfer_active(in_xfer),
        .burst_end  (burst_end),
        .xact_end   (xact_end),
        .cfg        (cfg),
        .en         (en),
        .rdata      (ctrl_rdata)
    );

    dma_trig_pick #(.NTRIG(NTRIG)) u_pick (
        .req(trig_req),
        .src(cfg.src),
        .arm(en),
        .hit(trig_hit)
    );

    dma_beat_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .CNW(FCW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rd_fire),
        .push_data(rd_data),
        .pop      (wr_fire),
        .head     (wr_data),
        .count    (fifo_cnt)
    );

    // datapath handshakes
    assign halt       = standby && !cfg.stby_run;
    assign in_xfer    = (q.st == ST_XFER);
    assign fifo_full  = (fifo_cnt == FCW'(FIFO_DEPTH));
    assign blen_beats = {1'b0, cfg.blen} + 5'd1;
    assign thr_eff    = (cfg.blen == 4'd0) ? 5'd1 : thr_beats(cfg.thr);

    assign rd_valid = in_xfer && en && !halt && (q.brst_left != '0) && !fifo_full;
    assign wr_valid = in_xfer && en && !halt && (fifo_cnt != '0) &&
                      ((32'(fifo_cnt) >= 32'(thr_eff)) || (q.brst_left == '0));
    assign rd_fire  = rd_valid && rd_ready;
    assign wr_fire  = wr_valid && wr_ready;

    assign burst_end = in_xfer && (q.brst_left == '0) && (fifo_cnt == '0);
    assign last_wr   = wr_fire && (q.brst_left == '0) && (q.blk_left == '0) &&
                       (fifo_cnt == FCW'(1));
    assign xact_end  = (cfg.act == ACT_XACT) && (q.blk_left == '0);
    assign load_len  = (q.blk_left == '0) ? blk_beats : q.blk_left;

    always_comb begin
        d      = q;
        d.done = last_wr;
        if (rd_fire) begin
            d.brst_left = q.brst_left - 1'b1;
            d.blk_left  = q.blk_left - 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                d.pend = 1'b0;
                if (en) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (trig_hit || q.pend) begin
                    d.pend = 1'b0;
                    if (load_len != '0) begin
                        d.blk_left  = load_len;
                        d.brst_left = clip(load_len, blen_beats);
                        d.st        = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (trig_hit) d.pend = 1'b1;
                if (burst_end) begin
                    if ((q.blk_left == '0) || (cfg.act == ACT_BURST)) begin
                        d.st = ST_WAIT;
                    end else begin
                        d.brst_left = clip(q.blk_left, blen_beats);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!en) begin
            d.st        = ST_IDLE;
            d.pend      = 1'b0;
            d.blk_left  = '0;
            d.brst_left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.blk_left  <= '0;
            q.brst_left <= '0;
            q.pend      <= 1'b0;
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy = in_xfer;
    assign done = q.done;

endmodule

// File: rtl/dma_burst_channel_chk.sv
module dma_burst_channel_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       standby,
    input logic [31:0]                ctrl_rdata,
    input logic                       rd_valid,
    input logic                       wr_valid,
    input logic                       busy,
    input logic                       done,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);

    assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !ctrl_rdata[6]) |-> (!rd_valid && !wr_valid));

    assert_swrst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[0] |=> (ctrl_rdata == 32'd0));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_drain_before_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rdata[1]) |-> ($past(fifo_cnt) == '0));

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[1] |-> (!rd_valid && !wr_valid));

    assert_rd_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fifo_cnt) <= DEPTH);

endmodule

bind dma_burst_channel dma_burst_channel_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .ctrl_rdata(ctrl_rdata),
    .rd_valid  (rd_valid),
    .wr_valid  (wr_valid),
    .busy      (busy),
    .done      (done),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/dma_burst_channel_bench.sv
module dma_burst_channel_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_we = 1'b0;
    logic [31:0]  ctrl_wdata = '0;
    logic [31:0]  ctrl_rdata;
    logic [15:0]  blk_beats = 16'd20;
    logic [255:0] trig_req = '0;
    logic         standby = 1'b0;
    logic         rd_valid;
    logic         rd_ready = 1'b1;
    logic [31:0]  rd_data;
    logic         wr_valid;
    logic         wr_ready = 1'b1;
    logic [31:0]  wr_data;
    logic         busy;
    logic         done;

    int n_chk = 0, n_bad = 0;
    int rd_seen = 0, wr_seen = 0, done_cnt = 0, late_done = 0, data_err = 0;
    int thr_obs = 0, thr_base = 0;
    bit arm_thr = 0, prev_wr = 0, finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign rd_data = 32'(rd_seen);

    dma_burst_channel u_dma_burst_channel (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .blk_beats(blk_beats), .trig_req(trig_req),
        .standby(standby), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    // port monitor, sampled mid-way between edges
    always @(negedge clk) begin
        #5;
        if (arm_thr && wr_valid) begin
            thr_obs = rd_seen - thr_base;
            arm_thr = 0;
        end
        if (done) begin
            done_cnt++;
            if (!prev_wr) late_done++;
        end
        prev_wr = wr_valid && wr_ready;
        if (rd_valid && rd_ready) rd_seen++;
        if (wr_valid && wr_ready) begin
            wr_seen++;
            if (wr_data !== 32'(wr_seen)) data_err++;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int thr, int blen, int act, int src, int run, int en, int sw);
        logic [31:0] w = '0;
        w[29:28] = thr[1:0];
        w[27:24] = blen[3:0];
        w[21:20] = act[1:0];
        w[15:8]  = src[7:0];
        w[6]     = run[0];
        w[1]     = en[0];
        w[0]     = sw[0];
        return w;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic wr_ctrl(input logic [31:0] w);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        trig_req[line] = 1'b1;
        @(negedge clk);
        trig_req[line] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_quiet();
        int lows = 0;
        for (int i = 0; i < 3000 && lows < 4; i++) begin
            @(negedge clk);
            if (!busy) lows++;
            else lows = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R13 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int b0, d0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "reset ctrl_rdata", ctrl_rdata, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset rd_valid/wr_valid", {rd_valid, wr_valid}, 0);
        chk("R12", "reset done", done, 0);

        // R1 layout, reserved bits read 0
        wr_ctrl(mk(2, 9, 3, 8'h5A, 1, 0, 0) | 32'hC0CF_00BC);
        chk("R1", "field layout", ctrl_rdata, mk(2, 9, 3, 8'h5A, 1, 0, 0));

        // R10 software reset while disabled
        wr_ctrl(mk(1, 4, 2, 8'h11, 0, 0, 1));
        chk("R10", "reset bit visible", ctrl_rdata[0], 1);
        @(negedge clk);
        chk("R10", "word cleared after reset", ctrl_rdata, 0);
        // R10 ignored while enabled
        wr_ctrl(mk(0, 3, 0, 0, 0, 1, 0));
        wr_ctrl(mk(1, 6, 0, 0, 1, 1, 1));
        chk("R10", "reset ignored while enabled", ctrl_rdata, mk(1, 6, 0, 0, 1, 1, 0));
        wr_ctrl(mk(1, 6, 0, 0, 1, 0, 0));
        chk("R9", "disable while waiting is immediate", ctrl_rdata[1], 0);

        // R2/R3/R4 sweep: burst granularity, all lengths and thresholds
        blk_beats = 16'd20;
        for (int n = 0; n < 16; n++) begin
            for (int t = 0; t < 4; t++) begin
                int rem;
                rem = 20;
                d0 = done_cnt;
                wr_ctrl(mk(t, n, 2, 5, 0, 1, 0));
                while (rem > 0) begin
                    int bs, et;
                    bs = imin(n + 1, rem);
                    et = (n == 0) ? 1 : imin(1 << t, bs);
                    b0 = rd_seen;
                    thr_base = rd_seen;
                    arm_thr = 1;
                    pulse(5);
                    wait_quiet();
                    chk("R2", $sformatf("beats per request n=%0d t=%0d", n, t), rd_seen - b0, bs);
                    chk("R3", $sformatf("reads before first write n=%0d t=%0d", n, t), thr_obs, et);
                    rem -= bs;
                end
                chk("R4", "one burst per request, block total", wr_seen, rd_seen);
                chk("R12", $sformatf("done count n=%0d t=%0d", n, t), done_cnt - d0, 1);
                wr_ctrl(mk(t, n, 2, 5, 0, 0, 0));
            end
        end

        // R5 block granularity and reserved code
        blk_beats = 16'd10;
        for (int a = 0; a < 2; a++) begin
            wr_ctrl(mk(0, 3, a, 7, 0, 1, 0));
            b0 = rd_seen;
            d0 = done_cnt;
            pulse(7);
            wait_quiet();
            chk("R5", $sformatf("block moved code %0d", a), rd_seen - b0, 10);
            chk("R5", "enable kept", ctrl_rdata[1], 1);
            chk("R12", "done once per block", done_cnt - d0, 1);
            wr_ctrl(mk(0, 3, a, 7, 0, 0, 0));
        end

        // R6 transaction granularity
        wr_ctrl(mk(1, 3, 3, 7, 0, 1, 0));
        b0 = rd_seen;
        pulse(7);
        wait_quiet();
        chk("R6", "transaction moved", rd_seen - b0, 10);
        chk("R6", "enable cleared", ctrl_rdata[1], 0);

        // R7 line selection
        wr_ctrl(mk(0, 3, 0, 0, 0, 1, 0));
        b0 = rd_seen;
        pulse(0);
        idle(20);
        chk("R7", "line 0 inactive", rd_seen - b0, 0);
        wr_ctrl(mk(0, 3, 0, 7, 0, 1, 0));
        pulse(8);
        idle(20);
        chk("R7", "unselected line ignored", rd_seen - b0, 0);
        pulse(7);
        wait_quiet();
        chk("R7", "selected line moves block", rd_seen - b0, 10);
        wr_ctrl(mk(0, 3, 0, 7, 0, 0, 0));

        // R8 single pending request
        blk_beats = 16'd40;
        wr_ready = 1'b0;
        wr_ctrl(mk(0, 7, 2, 9, 0, 1, 0));
        b0 = rd_seen;
        pulse(9);
        idle(3);
        pulse(9);
        pulse(9);
        pulse(9);
        wr_ready = 1'b1;
        wait_quiet();
        chk("R8", "one pending request kept", rd_seen - b0, 16);
        wr_ctrl(mk(0, 7, 2, 9, 0, 0, 0));

        // R9 disable drains current burst
        wr_ready = 1'b0;
        wr_ctrl(mk(0, 7, 0, 9, 0, 1, 0));
        b0 = rd_seen;
        d0 = done_cnt;
        pulse(9);
        idle(3);
        wr_ctrl(mk(0, 7, 0, 9, 0, 0, 0));
        chk("R9", "enable held during burst", ctrl_rdata[1], 1);
        idle(12);
        chk("R9", "enable held while buffer full", ctrl_rdata[1], 1);
        wr_ready = 1'b1;
        wait_quiet();
        chk("R9", "burst completed then stop", rd_seen - b0, 8);
        chk("R9", "enable cleared after drain", ctrl_rdata[1], 0);
        chk("R9", "abort gives no done", done_cnt - d0, 0);

        // R11 standby
        blk_beats = 16'd8;
        standby = 1'b1;
        wr_ctrl(mk(0, 3, 0, 7, 0, 1, 0));
        b0 = rd_seen;
        pulse(7);
        idle(20);
        chk("R11", "halted in standby", rd_seen - b0, 0);
        standby = 1'b0;
        wait_quiet();
        chk("R11", "resumes after standby", rd_seen - b0, 8);
        wr_ctrl(mk(0, 3, 0, 7, 1, 1, 0));
        standby = 1'b1;
        b0 = rd_seen;
        pulse(7);
        wait_quiet();
        chk("R11", "runs in standby when allowed", rd_seen - b0, 8);
        standby = 1'b0;
        wr_ctrl(mk(0, 3, 0, 7, 1, 0, 0));

        // R12 / R13 global
        idle(4);
        chk("R12", "done follows last write", late_done, 0);
        chk("R13", "write data order", data_err, 0);
        chk("R13", "reads equal writes", wr_seen, rd_seen);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule